// File: doc/BRIEF.md
# Byte Mailbox Word Framer

This block is a host-side master for a byte-wide mailbox shared with a coprocessor. It moves 32-bit words and length-prefixed byte slices over a small four-location bus: one location returns received bytes, one accepts bytes to send, and two return status bits. Each byte is handled in two steps. First the block polls the matching status location until the ready bit is set. Then it performs the single data access.

Words travel least significant byte first, and received words are rebuilt in the same order. A slice is a length word followed by exactly that many payload bytes. Outgoing payload is fetched from a local byte buffer, and incoming payload is stored into that buffer, starting at buffer address 0 in both cases.

A receive byte that never becomes ready is replaced by zero after a bounded wait. The transfer then continues with an error flag set. A transmit byte that never finds the register empty is not written, and the command ends with the error flag set. Both wait limits are parameters counted in clock cycles. Commands use a start/busy/done handshake.

Top module: `mbx_slice_master`

## Requirements
- R1: A read of the received-data location (bus address 0) happens only in the cycle right after a poll of the receive-status location (address 2) that returned bit 0 set.
- R2: A write to the send-data location (address 1) happens only in the cycle right after a poll of the send-status location (address 3) that returned bit 0 set. Read and write strobes are never active together.
- R3: `cmd_op` bit 0 selects receive (1) or send (0), and bit 1 selects slice (1) or word (0). A word command sends `cmd_word`, or rebuilds `rsp_word`, as four bytes with bits 7:0 first and bits 31:24 last.
- R4: A send slice (op 2) sends `cmd_word` as the length word. It then sends that many bytes read from buffer addresses 0, 1, 2, and so on. A length of 0 sends only the four length bytes.
- R5: A receive slice (op 3) reads a length word and then that many bytes, which are written to buffer addresses 0, 1, 2, and so on. `rsp_word` returns the length. A length of 0 makes no buffer write.
- R6: After RX_WAIT_LIMIT consecutive receive-status polls with bit 0 clear, the byte is taken as 0x00 and `cmd_err` is set. The rest of the transfer continues normally.
- R7: After TX_WAIT_LIMIT consecutive send-status polls with bit 0 clear, no write is made. The command ends at once with `cmd_err` set, and no later byte is sent.
- R8: `cmd_done` is a one-cycle pulse in the cycle `cmd_busy` falls. `rsp_word` and `cmd_err` stay unchanged from then until the next command is accepted.
- R9: A `cmd_start` that arrives while `cmd_busy` is high is ignored. It starts no transfer, either at once or afterwards.
- R10: In reset, and whenever `cmd_busy` is low, the bus strobes are inactive. After reset `cmd_busy`, `cmd_done` and `cmd_err` are 0. A reset in the middle of a command abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start request, accepted while not busy |
| cmd_op | input | 2 | Operation: bit 0 receive, bit 1 slice |
| cmd_word | input | WORD_W | Word to send or send-slice length |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | A byte timed out during the last command |
| rsp_word | output | WORD_W | Received word or received slice length |
| buf_addr | output | BUF_AW | Local buffer byte address |
| buf_rdata | input | 8 | Buffer byte at buf_addr (combinational) |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Byte to store |
| bus_addr | output | 2 | Mailbox location |
| bus_rd | output | 1 | Mailbox read strobe |
| bus_wr | output | 1 | Mailbox write strobe |
| bus_wdata | output | 8 | Byte to the send-data location |
| bus_rdata | input | 8 | Data or status from the addressed location |

## Verification
The bench throttles the status bits so that polls fail on alternate cycles. A design that skipped a poll, or reused a stale ready bit, would lose or repeat bytes. Zero-length slices are sent and received. A design that counted before testing would move stray payload bytes or write the buffer. A receive word runs dry after two bytes, and the result must be 0x00002211 with the error flag set. A design that stopped early, or that kept a stale byte, shows a different value. A blocked transmit must log no byte at all. A start issued mid-command must not produce a second transfer.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Mailbox locations; the coprocessor decodes these.
  localparam logic [1:0] LOC_RX_DATA = 2'd0;
  localparam logic [1:0] LOC_TX_DATA = 2'd1;
  localparam logic [1:0] LOC_RX_STAT = 2'd2;
  localparam logic [1:0] LOC_TX_STAT = 2'd3;

  // Command code: bit 0 = receive direction, bit 1 = slice framing.
  typedef enum logic [1:0] {
    OP_TX_WORD  = 2'd0,
    OP_RX_WORD  = 2'd1,
    OP_TX_SLICE = 2'd2,
    OP_RX_SLICE = 2'd3
  } mbx_op_e;

  typedef enum logic [1:0] {
    BP_IDLE = 2'd0,
    BP_POLL = 2'd1,
    BP_MOVE = 2'd2
  } bp_state_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HEAD = 2'd1,
    SQ_BODY = 2'd2
  } sq_state_e;
endpackage

// File: rtl/mbx_byte_port.sv
// One polled byte transfer: poll status, then one data access, or give up.
module mbx_byte_port
  import mbx_pkg::*;
#(
  parameter int RX_WAIT_LIMIT = 50_000_000,
  parameter int TX_WAIT_LIMIT = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       dir_rx,
  input  logic [7:0] tx_byte,
  output logic       ack,
  output logic       tmo,
  output logic [7:0] rx_byte,
  output logic [1:0] bus_addr,
  output logic       bus_rd,
  output logic       bus_wr,
  output logic [7:0] bus_wdata,
  input  logic [7:0] bus_rdata
);
  localparam int MAX_LIMIT = (RX_WAIT_LIMIT > TX_WAIT_LIMIT) ? RX_WAIT_LIMIT : TX_WAIT_LIMIT;
  localparam int CW        = $clog2(MAX_LIMIT + 1);

  bp_state_e     st_q, st_d;
  logic          dir_q, dir_d;
  logic [7:0]    txb_q, txb_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;

  assign lim       = dir_q ? CW'(RX_WAIT_LIMIT) : CW'(TX_WAIT_LIMIT);
  assign bus_wdata = txb_q;

  always_comb begin
    st_d     = st_q;
    dir_d    = dir_q;
    txb_d    = txb_q;
    cnt_d    = cnt_q;
    ack      = 1'b0;
    tmo      = 1'b0;
    rx_byte  = 8'h00;
    bus_rd   = 1'b0;
    bus_wr   = 1'b0;
    bus_addr = LOC_RX_DATA;
    unique case (st_q)
      BP_IDLE: begin
        if (req) begin
          st_d  = BP_POLL;
          dir_d = dir_rx;
          txb_d = tx_byte;
          cnt_d = '0;
        end
      end
      BP_POLL: begin
        bus_rd   = 1'b1;
        bus_addr = dir_q ? LOC_RX_STAT : LOC_TX_STAT;
        if (bus_rdata[0]) begin
          st_d = BP_MOVE;
        end else if (cnt_q == lim - 1'b1) begin
          ack  = 1'b1;
          tmo  = 1'b1;
          st_d = BP_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      BP_MOVE: begin
        ack  = 1'b1;
        st_d = BP_IDLE;
        if (dir_q) begin
          bus_rd   = 1'b1;
          bus_addr = LOC_RX_DATA;
          rx_byte  = bus_rdata;
        end else begin
          bus_wr   = 1'b1;
          bus_addr = LOC_TX_DATA;
        end
      end
      default: st_d = BP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BP_IDLE;
      dir_q <= 1'b0;
      txb_q <= 8'h00;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      dir_q <= dir_d;
      txb_q <= txb_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/mbx_word_pack.sv
// Shift register: emits its low byte, and shifts new bytes in at the top.
module mbx_word_pack #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              shift,
  input  logic [7:0]        in_byte,
  output logic [7:0]        lo_byte,
  output logic [WORD_W-1:0] nxt
);
  logic [WORD_W-1:0] sh_q;

  assign lo_byte = sh_q[7:0];
  assign nxt     = {in_byte, sh_q[WORD_W-1:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= load_val;
    else if (shift) sh_q <= nxt;
  end
endmodule

// File: rtl/mbx_slice_master.sv
module mbx_slice_master
  import mbx_pkg::*;
#(
  parameter int RX_WAIT_LIMIT = 50_000_000,
  parameter int TX_WAIT_LIMIT = 100_000_000,
  parameter int BUF_AW        = 10,
  parameter int WORD_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_word,
  output logic              cmd_busy,
  output logic              cmd_done,
  output logic              cmd_err,
  output logic [WORD_W-1:0] rsp_word,
  output logic [BUF_AW-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  output logic [1:0]        bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata
);
  localparam int NBYTES = WORD_W / 8;
  localparam int BIW    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [BIW-1:0] LAST_IDX = BIW'(NBYTES - 1);

  sq_state_e         sq_q, sq_d;
  logic [1:0]        op_q, op_d;
  logic [BIW-1:0]    bidx_q, bidx_d;
  logic [WORD_W-1:0] rem_q, rem_d, len_sel;
  logic [BUF_AW-1:0] ptr_q, ptr_d;
  logic              err_q, err_d, done_q, done_d;
  logic [WORD_W-1:0] rsp_q, rsp_d;

  logic              accept, is_rx, is_slice;
  logic              bp_ack, bp_tmo;
  logic [7:0]        bp_rx, bp_tx, pk_lo;
  logic [WORD_W-1:0] pk_nxt;

  assign accept   = cmd_start && (sq_q == SQ_IDLE);
  assign is_rx    = op_q[0];
  assign is_slice = op_q[1];
  assign bp_tx    = (sq_q == SQ_BODY) ? buf_rdata : pk_lo;
  assign len_sel  = is_rx ? pk_nxt : rem_q;

  mbx_byte_port #(
    .RX_WAIT_LIMIT(RX_WAIT_LIMIT),
    .TX_WAIT_LIMIT(TX_WAIT_LIMIT)
  ) u_port (
    .clk, .rst_n,
    .req      (sq_q != SQ_IDLE),
    .dir_rx   (is_rx),
    .tx_byte  (bp_tx),
    .ack      (bp_ack),
    .tmo      (bp_tmo),
    .rx_byte  (bp_rx),
    .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .bus_rdata
  );

  mbx_word_pack #(.WORD_W(WORD_W)) u_pack (
    .clk, .rst_n,
    .load     (accept),
    .load_val (cmd_op[0] ? '0 : cmd_word),
    .shift    (bp_ack && (sq_q == SQ_HEAD)),
    .in_byte  (bp_rx),
    .lo_byte  (pk_lo),
    .nxt      (pk_nxt)
  );

  always_comb begin
    sq_d   = sq_q;
    op_d   = op_q;
    bidx_d = bidx_q;
    rem_d  = rem_q;
    ptr_d  = ptr_q;
    err_d  = err_q;
    rsp_d  = rsp_q;
    done_d = 1'b0;
    unique case (sq_q)
      SQ_IDLE: begin
        if (accept) begin
          sq_d   = SQ_HEAD;
          op_d   = cmd_op;
          bidx_d = '0;
          ptr_d  = '0;
          rem_d  = cmd_word;
          err_d  = 1'b0;
          rsp_d  = '0;
        end
      end
      SQ_HEAD: begin
        if (bp_ack) begin
          if (bp_tmo && !is_rx) begin
            err_d = 1'b1; done_d = 1'b1; sq_d = SQ_IDLE;
          end else begin
            if (bp_tmo) err_d = 1'b1;
            bidx_d = bidx_q + 1'b1;
            if (bidx_q == LAST_IDX) begin
              if (is_rx) rsp_d = pk_nxt;
              if (!is_slice || len_sel == '0) begin
                done_d = 1'b1; sq_d = SQ_IDLE;
              end else begin
                rem_d = len_sel; sq_d = SQ_BODY;
              end
            end
          end
        end
      end
      SQ_BODY: begin
        if (bp_ack) begin
          if (bp_tmo && !is_rx) begin
            err_d = 1'b1; done_d = 1'b1; sq_d = SQ_IDLE;
          end else begin
            if (bp_tmo) err_d = 1'b1;
            ptr_d = ptr_q + 1'b1;
            rem_d = rem_q - 1'b1;
            if (rem_q == WORD_W'(1)) begin
              done_d = 1'b1; sq_d = SQ_IDLE;
            end
          end
        end
      end
      default: sq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q   <= SQ_IDLE;
      op_q   <= 2'b00;
      bidx_q <= '0;
      rem_q  <= '0;
      ptr_q  <= '0;
      err_q  <= 1'b0;
      rsp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sq_q   <= sq_d;
      op_q   <= op_d;
      bidx_q <= bidx_d;
      rem_q  <= rem_d;
      ptr_q  <= ptr_d;
      err_q  <= err_d;
      rsp_q  <= rsp_d;
      done_q <= done_d;
    end
  end

  assign cmd_busy  = (sq_q != SQ_IDLE);
  assign cmd_done  = done_q;
  assign cmd_err   = err_q;
  assign rsp_word  = rsp_q;
  assign buf_addr  = ptr_q;
  assign buf_we    = bp_ack && is_rx && (sq_q == SQ_BODY);
  assign buf_wdata = bp_rx;
endmodule

// File: rtl/mbx_slice_master_chk.sv
module mbx_slice_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [7:0] bus_rdata,
  input logic       cmd_busy,
  input logic       cmd_done,
  input logic       buf_we
);
  p_rd_after_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |-> $past(bus_rd && bus_addr == 2'd2 && bus_rdata[0]));

  p_wr_after_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(bus_rd && bus_addr == 2'd3 && bus_rdata[0]));

  p_no_rd_wr_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  // R5 / R6: a buffer store comes from a data read or from a failed final poll
  p_store_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (bus_rd && (bus_addr == 2'd0 || (bus_addr == 2'd2 && !bus_rdata[0]))));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  p_busy_fall_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_busy) |-> cmd_done);

  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_busy |-> !(bus_rd || bus_wr));
endmodule

bind mbx_slice_master mbx_slice_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .cmd_busy  (cmd_busy),
  .cmd_done  (cmd_done),
  .buf_we    (buf_we)
);

// File: tb/sim_mbx_slice_master.sv
module sim_mbx_slice_master;
  localparam int CLK_PERIOD = 10;
  localparam int RXL = 6;
  localparam int TXL = 5;
  localparam int AW  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_word = '0;
  logic        cmd_busy, cmd_done, cmd_err;
  logic [31:0] rsp_word;
  logic [AW-1:0] buf_addr;
  logic [7:0]  buf_rdata, buf_wdata, bus_wdata, bus_rdata;
  logic        buf_we, bus_rd, bus_wr;
  logic [1:0]  bus_addr;

  // coprocessor and buffer model
  logic [7:0] rxq [0:255];
  logic [7:0] txl [0:255];
  logic [7:0] src_mem [0:15];
  logic [7:0] dst_mem [0:15];
  int rxq_n = 0, rxq_rd = 0, txl_n = 0, we_cnt = 0;
  logic rx_en = 1'b1, tx_en = 1'b1, slow = 1'b0;
  logic [31:0] cyc = '0;
  logic rx_full, tx_empty;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_full   = rx_en && (rxq_rd < rxq_n) && (!slow || cyc[0]);
  assign tx_empty  = tx_en && (!slow || cyc[0]);
  assign buf_rdata = src_mem[buf_addr];

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = rxq[rxq_rd[7:0]];
      2'd2:    bus_rdata = {7'b0, rx_full};
      2'd3:    bus_rdata = {7'b0, tx_empty};
      default: bus_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_rd && bus_addr == 2'd0) rxq_rd <= rxq_rd + 1;
    if (bus_wr) begin
      txl[txl_n[7:0]] <= bus_wdata;
      txl_n <= txl_n + 1;
    end
    if (buf_we) begin
      dst_mem[buf_addr] <= buf_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  mbx_slice_master #(
    .RX_WAIT_LIMIT(RXL), .TX_WAIT_LIMIT(TXL), .BUF_AW(AW), .WORD_W(32)
  ) u0 (
    .clk, .rst_n, .cmd_start, .cmd_op, .cmd_word, .cmd_busy, .cmd_done,
    .cmd_err, .rsp_word, .buf_addr, .buf_rdata, .buf_we, .buf_wdata,
    .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .bus_rdata
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    rxq[rxq_n[7:0]] = b;
    rxq_n++;
  endtask

  task automatic push_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) push_byte(w[8*i +: 8]);
  endtask

  function automatic logic [31:0] tx_word(input int base);
    return {txl[base+3], txl[base+2], txl[base+1], txl[base]};
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [31:0] w);
    @(negedge clk);
    cmd_start = 1'b1; cmd_op = op; cmd_word = w;
    @(negedge clk);
    cmd_start = 1'b0;
    do @(negedge clk); while (!cmd_done);
  endtask

  // op(2) slow(1) word(32)
  localparam logic [34:0] VEC [4] = '{
    {2'd0, 1'b0, 32'h1234_5678},
    {2'd0, 1'b1, 32'hDEAD_BEEF},
    {2'd1, 1'b0, 32'hCAFE_F00D},
    {2'd1, 1'b1, 32'h00FF_0180}
  };

  initial begin
    for (int i = 0; i < 16; i++) begin
      src_mem[i] = 8'h50 + 8'(i);
      dst_mem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 busy in reset", {31'b0, cmd_busy}, 32'd0);
    check("R10 strobes in reset", {30'b0, bus_rd, bus_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 done/err after reset", {30'b0, cmd_done, cmd_err}, 32'd0);

    // R3: word table, byte order in both directions, with throttled status (R1, R2)
    for (int v = 0; v < 4; v++) begin
      int base;
      slow = VEC[v][32];
      base = txl_n;
      if (VEC[v][33]) push_word(VEC[v][31:0]);
      run_cmd(VEC[v][34:33], VEC[v][31:0]);
      if (VEC[v][33]) check("R3 rx word", rsp_word, VEC[v][31:0]);
      else begin
        check("R3 tx byte count", 32'(txl_n - base), 32'd4);
        check("R3 tx word order", tx_word(base), VEC[v][31:0]);
      end
      check("R3 no error", {31'b0, cmd_err}, 32'd0);
    end
    slow = 1'b0;

    // R8: response held after done
    repeat (5) @(negedge clk);
    check("R8 rsp held", rsp_word, 32'h00FF_0180);
    check("R8 done single pulse", {31'b0, cmd_done}, 32'd0);

    // R4: send slice, length 5, then length 0
    begin
      int base;
      base = txl_n;
      run_cmd(2'd2, 32'd5);
      check("R4 slice byte count", 32'(txl_n - base), 32'd9);
      check("R4 length word", tx_word(base), 32'd5);
      check("R4 payload 0..3", tx_word(base + 4), 32'h5352_5150);
      check("R4 payload last", {24'b0, txl[base+8]}, 32'h54);
      base = txl_n;
      run_cmd(2'd2, 32'd0);
      check("R4 zero length sends header only", 32'(txl_n - base), 32'd4);
      check("R4 zero length word", tx_word(base), 32'd0);
    end

    // R5: receive slice, length 3, then length 0
    begin
      int wb;
      push_word(32'd3); push_byte(8'hAA); push_byte(8'hBB); push_byte(8'hCC);
      slow = 1'b1;
      wb = we_cnt;
      run_cmd(2'd3, 32'd0);
      slow = 1'b0;
      check("R5 length reported", rsp_word, 32'd3);
      check("R5 stores", 32'(we_cnt - wb), 32'd3);
      check("R5 buffer bytes", {8'h00, dst_mem[2], dst_mem[1], dst_mem[0]}, 32'h00CC_BBAA);
      wb = we_cnt;
      push_word(32'd0);
      run_cmd(2'd3, 32'd0);
      check("R5 zero length rsp", rsp_word, 32'd0);
      check("R5 zero length no store", 32'(we_cnt - wb), 32'd0);
      check("R5 queue drained", 32'(rxq_n - rxq_rd), 32'd0);
    end

    // R6: receive runs dry after two bytes
    push_byte(8'h11); push_byte(8'h22);
    run_cmd(2'd1, 32'd0);
    check("R6 partial word zero filled", rsp_word, 32'h0000_2211);
    check("R6 error flag", {31'b0, cmd_err}, 32'd1);

    // R7: blocked transmit writes nothing
    begin
      int base;
      tx_en = 1'b0;
      base = txl_n;
      run_cmd(2'd0, 32'hA5A5_A5A5);
      check("R7 no write on timeout", 32'(txl_n - base), 32'd0);
      check("R7 error flag", {31'b0, cmd_err}, 32'd1);
      tx_en = 1'b1;
    end

    // R9: start while busy ignored
    begin
      int base;
      base = txl_n;
      @(negedge clk);
      cmd_start = 1'b1; cmd_op = 2'd0; cmd_word = 32'hA1B2_C3D4;
      @(negedge clk);
      cmd_start = 1'b0;
      @(negedge clk);
      cmd_start = 1'b1; cmd_word = 32'hFFFF_FFFF;
      @(negedge clk);
      cmd_start = 1'b0;
      do @(negedge clk); while (!cmd_done);
      check("R9 first command bytes", tx_word(base), 32'hA1B2_C3D4);
      check("R8 error cleared on new command", {31'b0, cmd_err}, 32'd0);
      repeat (10) @(negedge clk);
      check("R9 no extra transfer", 32'(txl_n - base), 32'd4);
      check("R9 idle afterwards", {31'b0, cmd_busy}, 32'd0);
    end

    // R10: reset mid-command
    rx_en = 1'b0;
    @(negedge clk);
    cmd_start = 1'b1; cmd_op = 2'd1;
    @(negedge clk);
    cmd_start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 abandon on reset", {29'b0, cmd_busy, bus_rd, bus_wr}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 stays idle after reset", {31'b0, cmd_busy}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule